// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block generates the column address for every beat of an SDRAM read or write burst. A controller pulses `start_i` together with the starting column, a read/write flag and the current mode-register word. On each following clock the block presents one column on `col_o`, marked by `valid_o`. It raises `last_o` on the final beat of a fixed-length burst and pulses `done_o` in the cycle after a burst ends. Sequential and interleaved orderings are both produced. Fixed bursts of 2, 4 or 8 wrap inside their aligned block. Full-page bursts wrap across the whole row and stop only when `stop_i` is asserted.

The control is a three-state machine. `ST_IDLE` emits nothing. `ST_FIXED` steps a burst of 1, 2, 4 or 8 beats. `ST_PAGE` steps a full-page burst. The named transitions are:
- *launch*: from any state to `ST_FIXED` or `ST_PAGE` when `start_i` is high; a launch also replaces a burst that is running.
- *advance*: `ST_FIXED` to itself, or `ST_PAGE` to itself, stepping the beat index.
- *finish*: `ST_FIXED` to `ST_IDLE` after the last beat.
- *cut*: `ST_FIXED` or `ST_PAGE` to `ST_IDLE` when `stop_i` is high.
- *rest*: `ST_IDLE` to itself.

The mode word uses these fields:
- Bits [2:0] are the length code.
- Bit 3 is the ordering.
- Bit 9 forces write bursts to a single beat.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `valid_o`, `last_o`, `done_o` and `cfg_err_o` are all 0.
- R2: When `start_i` is high at a clock edge, from the next cycle `valid_o` is 1 and `col_o` equals the sampled start column. A start is accepted on any cycle, replaces a burst in progress and takes priority over `stop_i`.
- R3: The length code in mode bits [2:0] selects the beat count: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives a full page. `last_o` is high on the final beat of a fixed burst, and `valid_o` is 0 in the following cycle unless a new start arrived.
- R4: With mode bit 3 = 0 (sequential), beat k holds the start's upper bits unchanged. Its low log2(length) bits are (start + k) mod length; for example, start low bits 5 with length 8 give 5,6,7,0,1,2,3,4.
- R5: With mode bit 3 = 1 (interleaved), beat k's low bits are the start's low bits XOR k, and the upper bits are unchanged; for example, start low bits 5 with length 8 give 5,4,7,6,1,0,3,2.
- R6: With length code 000 exactly one beat, equal to the start column, is produced whatever the value of mode bit 3.
- R7: A full-page burst counts the whole 9-bit column upward from the start and wraps from 511 to 0. It never raises `last_o` and runs until stopped.
- R8: When `stop_i` is high and `start_i` is low at an edge, no valid beat appears from the next cycle on.
- R9: `done_o` is a one-cycle pulse in the cycle after a burst ends by its last beat or by `stop_i`. It does not pulse when a burst is replaced by a new start.
- R10: When mode bit 9 = 1, a write start (`is_write_i` = 1) produces a single beat, while a read start keeps the programmed length.
- R11: Full page with mode bit 3 = 1 is an unsupported configuration. The burst runs in sequential order and `cfg_err_o` is high on each of its beats.
- R12: A reserved length code (100, 101, 110) raises `cfg_err_o` on its beat and produces a single-beat burst. `cfg_err_o` is 0 whenever `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a new burst |
| is_write_i | input | 1 | 1 = write burst, 0 = read burst |
| start_col_i | input | COL_W (9) | Starting column |
| mode_i | input | MODE_W (10) | Mode word: [2:0] length, [3] ordering, [9] single-beat writes |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W (9) | Column of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Final beat of a fixed-length burst |
| done_o | output | 1 | Burst ended in the previous cycle |
| cfg_err_o | output | 1 | Running burst has an unsupported or reserved configuration |

## Verification
The bench builds the block with its default 9-bit column and 10-bit mode word. The 9-bit column is what lets a full-page burst show its 511-to-0 wrap within a few hundred cycles. The 10-bit mode word places both the ordering bit and the single-beat-write bit in range. Directed runs compare literal 8-beat orderings for each ordering type and a full-page wrap started at column 500. Random bursts then mix restarts, stops, reserved codes and single-beat writes at arbitrary beats.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;
endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode #(
    parameter int COL_W  = 9,
    parameter int MODE_W = 10,
    parameter int ORD_BIT = 3,
    parameter int WSB_BIT = 9
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              is_write_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              page_o,
    output logic              ilv_o,
    output logic              err_o
);
    import bcg_pkg::*;

    logic [3:0] lg_w;
    logic       page_w;
    logic       reserved_w;

    always_comb begin
        lg_w       = 4'd0;
        page_w     = 1'b0;
        reserved_w = 1'b0;
        case (mode_i[2:0])
            LEN_1:    lg_w = 4'd0;
            LEN_2:    lg_w = 4'd1;
            LEN_4:    lg_w = 4'd2;
            LEN_8:    lg_w = 4'd3;
            LEN_PAGE: page_w = 1'b1;
            default:  reserved_w = 1'b1;
        endcase
        err_o = reserved_w | (page_w & mode_i[ORD_BIT]);
        if (is_write_i && mode_i[WSB_BIT]) begin
            lg_w   = 4'd0;
            page_w = 1'b0;
        end
        page_o = page_w;
        ilv_o  = mode_i[ORD_BIT] & ~page_w;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask_o[i] = page_w | (int'(lg_w) > i);
    end
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum_w;
    logic [COL_W-1:0] xor_w;
    logic [COL_W-1:0] low_w;

    assign sum_w = base_i + beat_i;
    assign xor_w = base_i ^ beat_i;
    assign low_w = ilv_i ? xor_w : sum_w;
    assign col_o = (base_i & ~mask_i) | (low_w & mask_i);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W  = 9,
    parameter int MODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              done_o,
    output logic              cfg_err_o
);
    import bcg_pkg::*;

    bcg_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             ilv_q, err_q, done_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page, dec_ilv, dec_err;
    logic             at_last;
    logic [COL_W-1:0] calc_col;

    bcg_mode_decode #(.COL_W(COL_W), .MODE_W(MODE_W)) u_dec (
        .mode_i     (mode_i),
        .is_write_i (is_write_i),
        .mask_o     (dec_mask),
        .page_o     (dec_page),
        .ilv_o      (dec_ilv),
        .err_o      (dec_err)
    );

    bcg_addr_calc #(.COL_W(COL_W)) u_calc (
        .base_i (base_q),
        .beat_i (beat_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (calc_col)
    );

    assign at_last = (beat_q == mask_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = dec_page ? ST_PAGE : ST_FIXED;
            end
            ST_FIXED: begin
                if (start_i)                 state_d = dec_page ? ST_PAGE : ST_FIXED;
                else if (stop_i || at_last)  state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (start_i)      state_d = dec_page ? ST_PAGE : ST_FIXED;
                else if (stop_i)  state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (state_q != ST_IDLE) && !start_i && (state_d == ST_IDLE);
            if (start_i) begin
                base_q <= start_col_i;
                beat_q <= '0;
                mask_q <= dec_mask;
                ilv_q  <= dec_ilv;
                err_q  <= dec_err;
            end else if (state_q != ST_IDLE) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        valid_o   = (state_q != ST_IDLE);
        last_o    = (state_q == ST_FIXED) && at_last;
        cfg_err_o = valid_o && err_q;
        done_o    = done_q;
        col_o     = calc_col;
    end
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             stop_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             done_o,
    input logic             cfg_err_o
);
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    assert_last_is_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    assert_last_then_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> (!valid_o && done_o));

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_err_in_burst_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> valid_o);
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .done_o      (done_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       is_write_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [9:0] mode_i = '0;
    logic       stop_i = 1'b0;
    logic [8:0] col_o;
    logic       valid_o, last_o, done_o, cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    string tag = "R1";

    // model state
    bit m_act = 0, m_page = 0, m_ilv = 0, m_err = 0, m_done = 0;
    int m_start = 0, m_beat = 0, m_len = 1;

    always #5 clk = ~clk;

    burst_col_gen u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
        .start_col_i(start_col_i), .mode_i(mode_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .done_o(done_o),
        .cfg_err_o(cfg_err_o)
    );

    function automatic logic [9:0] mk_mode(input int code, input bit ord, input bit ws);
        return {ws, 5'b0, ord, 3'(code)};
    endfunction

    function automatic int exp_col(input int st, input int bt, input int len, input bit ilv);
        int mask = len - 1;
        int low  = ilv ? (st ^ bt) : (st + bt);
        return ((st & ~mask) | (low & mask)) & 511;
    endfunction

    task automatic chk(input string t, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic model_edge(input bit s, input bit w, input int c, input logic [9:0] m, input bit p);
        if (s) begin
            int code = int'(m[2:0]);
            bit rsv = !(code <= 3 || code == 7);
            m_len = (code == 7) ? 512 : (rsv ? 1 : (1 << code));
            m_err = rsv || (code == 7 && m[3]);
            if (w && m[9]) m_len = 1;
            m_page = (m_len == 512);
            m_ilv = m[3] && !m_page;
            m_act = 1; m_start = c; m_beat = 0; m_done = 0;
        end else if (m_act && (p || (!m_page && m_beat == m_len - 1))) begin
            m_act = 0; m_done = 1;
        end else begin
            m_done = 0;
            if (m_act) m_beat = (m_beat + 1) % 512;
        end
    endtask

    task automatic compare_all();
        chk({tag, " valid"}, int'(valid_o), int'(m_act));
        chk({tag, " done"}, int'(done_o), int'(m_done));
        chk({tag, " err"}, int'(cfg_err_o), int'(m_act && m_err));
        chk({tag, " last"}, int'(last_o), int'(m_act && !m_page && m_beat == m_len - 1));
        if (m_act) chk({tag, " col"}, int'(col_o), exp_col(m_start, m_beat, m_len, m_ilv));
    endtask

    task automatic step(input bit s, input bit w, input int c, input logic [9:0] m, input bit p);
        @(negedge clk);
        start_i = s; is_write_i = w; start_col_i = 9'(c); mode_i = m; stop_i = p;
        @(posedge clk);
        model_edge(s, w, c, m, p);
        #2;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 10'd0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seq_exp[8] = '{5, 6, 7, 0, 1, 2, 3, 4};
        int ilv_exp[8] = '{5, 4, 7, 6, 1, 0, 3, 2};
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        tag = "R1";
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 last", int'(last_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 err", int'(cfg_err_o), 0);
        @(negedge clk); rst_n = 1'b1;

        // R4 sequential literal order, start 168+5
        tag = "R4";
        step(1, 0, 173, mk_mode(3, 0, 0), 0);
        for (int k = 0; k < 8; k++) begin
            chk("R4 seq order", int'(col_o), 168 + seq_exp[k]);
            if (k < 7) step(0, 0, 0, 10'd0, 0);
        end
        tag = "R3"; step(0, 0, 0, 10'd0, 0);
        chk("R3 valid drops after last", int'(valid_o), 0);
        tag = "R9"; step(0, 0, 0, 10'd0, 0);

        // R5 interleaved literal order
        tag = "R5";
        step(1, 0, 173, mk_mode(3, 1, 0), 0);
        for (int k = 0; k < 8; k++) begin
            chk("R5 ilv order", int'(col_o), 168 + ilv_exp[k]);
            if (k < 7) step(0, 0, 0, 10'd0, 0);
        end
        tag = "R5"; idle(2);

        // R3 length 2 and 4 wrap
        tag = "R3"; step(1, 1, 9'h013, mk_mode(1, 0, 0), 0); idle(3);
        tag = "R3"; step(1, 0, 9'h0FE, mk_mode(2, 1, 0), 0); idle(5);

        // R6 length 1 ignores type
        tag = "R6"; step(1, 0, 77, mk_mode(0, 1, 0), 0);
        chk("R6 single col", int'(col_o), 77);
        chk("R6 single last", int'(last_o), 1);
        idle(2);

        // R7 full page wrap, R8 stop
        tag = "R7"; step(1, 0, 500, mk_mode(7, 0, 0), 0);
        for (int k = 1; k < 520; k++) step(0, 0, 0, 10'd0, 0);
        chk("R7 still running", int'(valid_o), 1);
        tag = "R8"; step(0, 0, 0, 10'd0, 1);
        chk("R8 no beat after stop", int'(valid_o), 0);
        tag = "R9"; idle(2);

        // R11 page + interleave
        tag = "R11"; step(1, 0, 510, mk_mode(7, 1, 0), 0);
        chk("R11 err flag", int'(cfg_err_o), 1);
        idle(4); step(0, 0, 0, 10'd0, 1); idle(1);

        // R12 reserved codes
        tag = "R12"; step(1, 0, 33, mk_mode(5, 0, 0), 0);
        chk("R12 err", int'(cfg_err_o), 1);
        idle(2);

        // R10 write single vs read
        tag = "R10"; step(1, 1, 40, mk_mode(3, 0, 1), 0);
        chk("R10 write single last", int'(last_o), 1);
        idle(1);
        step(1, 0, 40, mk_mode(3, 0, 1), 0);
        chk("R10 read keeps length", int'(last_o), 0);
        // R2 replacement mid-burst, start wins over stop
        tag = "R2"; step(1, 0, 300, mk_mode(2, 0, 0), 1);
        chk("R2 replaced col", int'(col_o), 300);
        tag = "R9"; step(0, 0, 0, 10'd0, 0);
        idle(5);

        // constrained random
        for (int b = 0; b < 400; b++) begin
            int codes[6] = '{0, 1, 2, 3, 7, 4};
            int code = codes[$urandom % 6];
            if (code == 4) code = 4 + ($urandom % 3);
            tag = "R2";
            step(1, bit'($urandom % 2), int'($urandom % 512),
                 mk_mode(code, bit'($urandom % 2), bit'($urandom % 2)), 0);
            for (int c = 0; c < 12; c++) begin
                int r = int'($urandom % 16);
                if (r == 0) begin
                    tag = "R2";
                    step(1, bit'($urandom % 2), int'($urandom % 512),
                         mk_mode(int'($urandom % 8), bit'($urandom % 2), bit'($urandom % 2)), 0);
                end else if (r == 1) begin
                    tag = "R8"; step(0, 0, 0, 10'd0, 1);
                end else begin
                    tag = "R4"; step(0, 0, 0, 10'd0, 0);
                end
            end
            tag = "R8"; step(0, 0, 0, 10'd0, 1);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule